// File: doc/BRIEF.md
# Hash Engine Interrupt Status and Enable Unit

This block gathers single-cycle event pulses from a hash core and from the DMA engine that feeds it. It turns them into one level-sensitive interrupt line. Each event sets a sticky bit in one of two status banks: a 4-bit core bank and a 9-bit DMA bank. A bit stays set until software clears it by writing a one to that position. Each bank has its own enable register, which decides which held bits reach the interrupt. The DMA bank has one more gate: a single-bit mask.

Software reaches the block through a simple register port. A write strobe, an address and write data update the registers. Read data is driven combinationally from the address. The usual flow is:
1. Clear everything pending by writing all ones.
2. Program the enables (and, for the DMA bank, the mask).
3. Wait for the interrupt.
4. Read a status bank, then write the value just read back to it.

Step 4 removes exactly the events that software has seen.

Register map (index on `reg_addr`):
- 0: core status, write-one-to-clear.
- 1: core enable.
- 2: DMA status, write-one-to-clear.
- 3: DMA enable.
- 4: DMA mask. Bit 0 set lets the DMA bank through.

Top module: `isr_unit`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and `irq` is low.
- R2: A pulse on `core_evt[i]` sets core status bit i at the next clock edge whatever the enables hold. The bit stays set until it is cleared. Core bit 2 means hash done; bits 0, 1 and 3 are hash errors.
- R3: DMA status bits 0 and 2 through 8 latch pulses on `dma_evt` the same way. Bit 0 means source transfer done; bits 2 to 8 are fault causes. Bit 1 does not exist: it always reads 0 and never sets.
- R4: Writing a value to a status address (0 or 2) clears exactly the bits that are one in the value and leaves the others. Writing all ones clears the whole bank. A write to a status address never sets a bit.
- R5: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R6: One cycle after any edge, `irq` equals the state of the registers at that edge. It is high when (core status AND core enable) is nonzero. It is also high when (DMA status AND DMA enable) is nonzero and mask bit 0 is one.
- R7: With mask bit 0 at zero, held and enabled DMA bits do not raise `irq`, and the core path is unaffected.
- R8: The enable registers (addresses 1 and 3) and the mask (address 4) read back the written value, limited to the bits that exist. Writing zero to an enable stops its bank from raising `irq`.
- R9: Writes to addresses 5 to 7 change nothing, and reads there return zero.
- R10: An enabled error bit raises `irq` even while a done bit in the same bank is also set but not enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| core_evt | input | 4 | Hash core event pulses |
| dma_evt | input | 9 | DMA event pulses |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that `core_evt`, `dma_evt`, `reg_wr` and `reg_addr` are known and stable around every sampling edge. They also assume that a write strobe lasts only the cycle it is meant for. The bench meets both assumptions by changing every input on the falling edge only and returning the strobe and the pulses to zero after each step. Random traffic mixes sparse events, overlapping clears, all-ones clears and writes to unused addresses. This drives collisions between clears and events and toggles of the enables and mask. A bench model of both banks predicts the interrupt every cycle and the read data of a randomly chosen register.

// File: rtl/isr_pkg.sv
// Shared widths, implemented-bit maps and register indices for the
// interrupt status unit. Assumes a 32-bit register data path.
package isr_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 3;
    localparam int CORE_W  = 4;
    localparam int DMA_W   = 9;
    localparam logic [CORE_W-1:0] CORE_IMPL = 4'b1111;
    localparam logic [DMA_W-1:0]  DMA_IMPL  = 9'b1_1111_1101;
    localparam logic [CORE_W-1:0] CORE_ERR  = 4'b1011;

    typedef enum logic [ADDR_W-1:0] {
        RA_CORE_STAT = 3'd0,
        RA_CORE_EN   = 3'd1,
        RA_DMA_STAT  = 3'd2,
        RA_DMA_EN    = 3'd3,
        RA_DMA_MASK  = 3'd4
    } isr_addr_e;
endpackage

// File: rtl/isr_status_bank.sv
// One status/enable bank. Each bit that exists holds a sticky status
// flop and an enable flop. Bits that do not exist read zero.
// Assumes: evt_i are single-cycle pulses and clr_we/en_we last one cycle.
// A set by an event wins over a clear in the same cycle.
module isr_status_bank #(
    parameter int            W    = 4,
    parameter logic [W-1:0]  IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         clr_we,
    input  logic         en_we,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] status_o,
    output logic [W-1:0] enable_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        if (IMPL[b]) begin : g_impl
            logic st_q;
            logic en_q;
            // sticky status: event sets, write-one clears, event wins
            always_ff @(posedge clk) begin
                if (!rst_n)
                    st_q <= 1'b0;
                else
                    st_q <= evt_i[b] | (st_q & ~(clr_we & wdata_i[b]));
            end
            // enable bit: loaded by a write to the enable register
            always_ff @(posedge clk) begin
                if (!rst_n)
                    en_q <= 1'b0;
                else if (en_we)
                    en_q <= wdata_i[b];
            end
            assign status_o[b] = st_q;
            assign enable_o[b] = en_q;
        end else begin : g_tie
            assign status_o[b] = 1'b0;
            assign enable_o[b] = 1'b0;
        end
    end

    // R2
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_i & IMPL)) |=> ((status_o & $past(evt_i & IMPL)) == $past(evt_i & IMPL)));

    // R4
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((status_o & ~$past(status_o) & ~$past(evt_i)) == '0));

    // R5
    clear_applies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && |(wdata_i & ~evt_i)) |=> ((status_o & $past(wdata_i & ~evt_i)) == '0));

    // R3
    absent_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o | enable_o) & ~IMPL) == '0);
endmodule

// File: rtl/isr_reg_decode.sv
// Register port decode. Turns the write strobe and index into per-register
// write enables, and selects the read data. Assumes reg_addr is stable
// while reg_rdata is sampled. Unused indices read zero and ignore writes.
module isr_reg_decode
    import isr_pkg::*;
#(
    parameter int D_W = DATA_W,
    parameter int A_W = ADDR_W,
    parameter int C_W = CORE_W,
    parameter int M_W = DMA_W
) (
    input  logic           reg_wr,
    input  logic [A_W-1:0] reg_addr,
    input  logic [C_W-1:0] core_stat,
    input  logic [C_W-1:0] core_en,
    input  logic [M_W-1:0] dma_stat,
    input  logic [M_W-1:0] dma_en,
    input  logic           dma_mask,
    output logic           core_clr_we,
    output logic           core_en_we,
    output logic           dma_clr_we,
    output logic           dma_en_we,
    output logic           mask_we,
    output logic [D_W-1:0] reg_rdata
);
    // write enables, one per register
    always_comb begin
        core_clr_we = reg_wr && (reg_addr == RA_CORE_STAT);
        core_en_we  = reg_wr && (reg_addr == RA_CORE_EN);
        dma_clr_we  = reg_wr && (reg_addr == RA_DMA_STAT);
        dma_en_we   = reg_wr && (reg_addr == RA_DMA_EN);
        mask_we     = reg_wr && (reg_addr == RA_DMA_MASK);
    end

    // read multiplexer, zero-extended
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CORE_STAT: reg_rdata[C_W-1:0] = core_stat;
            RA_CORE_EN:   reg_rdata[C_W-1:0] = core_en;
            RA_DMA_STAT:  reg_rdata[M_W-1:0] = dma_stat;
            RA_DMA_EN:    reg_rdata[M_W-1:0] = dma_en;
            RA_DMA_MASK:  reg_rdata[0]       = dma_mask;
            default:      reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/isr_irq_merge.sv
// Combines both banks into one registered interrupt request and holds
// the DMA mask flop. Assumes the status and enable inputs come from flops.
module isr_irq_merge #(
    parameter int C_W = 4,
    parameter int M_W = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [C_W-1:0] core_stat,
    input  logic [C_W-1:0] core_en,
    input  logic [M_W-1:0] dma_stat,
    input  logic [M_W-1:0] dma_en,
    input  logic           mask_we,
    input  logic           mask_wbit,
    output logic           dma_mask,
    output logic           irq
);
    logic core_hit;
    logic dma_hit;

    // per-bank pending reduction
    always_comb begin
        core_hit = |(core_stat & core_en);
        dma_hit  = (|(dma_stat & dma_en)) & dma_mask;
    end

    // mask register: bit 0 opens the DMA path
    always_ff @(posedge clk) begin
        if (!rst_n)
            dma_mask <= 1'b0;
        else if (mask_we)
            dma_mask <= mask_wbit;
    end

    // interrupt output flop
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= core_hit | dma_hit;
    end
endmodule

// File: rtl/isr_unit.sv
// Top of the interrupt status unit: a core bank, a DMA bank, register
// decode and interrupt merge. Assumes a single clock domain and a
// synchronous active-low reset.
module isr_unit
    import isr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [CORE_W-1:0] core_evt,
    input  logic [DMA_W-1:0]  dma_evt,
    output logic              irq
);
    logic [CORE_W-1:0] core_stat, core_en;
    logic [DMA_W-1:0]  dma_stat, dma_en;
    logic              dma_mask;
    logic core_clr_we, core_en_we, dma_clr_we, dma_en_we, mask_we;
    logic unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:DMA_W];

    isr_reg_decode #(.D_W(DATA_W), .A_W(ADDR_W), .C_W(CORE_W), .M_W(DMA_W)) u_dec (
        .reg_wr(reg_wr), .reg_addr(reg_addr),
        .core_stat(core_stat), .core_en(core_en),
        .dma_stat(dma_stat), .dma_en(dma_en), .dma_mask(dma_mask),
        .core_clr_we(core_clr_we), .core_en_we(core_en_we),
        .dma_clr_we(dma_clr_we), .dma_en_we(dma_en_we), .mask_we(mask_we),
        .reg_rdata(reg_rdata)
    );

    isr_status_bank #(.W(CORE_W), .IMPL(CORE_IMPL)) u_core (
        .clk(clk), .rst_n(rst_n), .evt_i(core_evt),
        .clr_we(core_clr_we), .en_we(core_en_we),
        .wdata_i(reg_wdata[CORE_W-1:0]),
        .status_o(core_stat), .enable_o(core_en)
    );

    isr_status_bank #(.W(DMA_W), .IMPL(DMA_IMPL)) u_dma (
        .clk(clk), .rst_n(rst_n), .evt_i(dma_evt),
        .clr_we(dma_clr_we), .en_we(dma_en_we),
        .wdata_i(reg_wdata[DMA_W-1:0]),
        .status_o(dma_stat), .enable_o(dma_en)
    );

    isr_irq_merge #(.C_W(CORE_W), .M_W(DMA_W)) u_merge (
        .clk(clk), .rst_n(rst_n),
        .core_stat(core_stat), .core_en(core_en),
        .dma_stat(dma_stat), .dma_en(dma_en),
        .mask_we(mask_we), .mask_wbit(reg_wdata[0]),
        .dma_mask(dma_mask), .irq(irq)
    );

    // R6
    irq_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq == $past((|(core_stat & core_en)) ||
                                ((|(dma_stat & dma_en)) && dma_mask))));

    // R7
    mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_mask && !(|(core_stat & core_en))) |=> !irq);

    // R10
    err_reported_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(core_stat & core_en & CORE_ERR)) |=> irq);
endmodule

// File: tb/test_isr_unit.sv
module test_isr_unit;
    localparam int CLK_PERIOD = 10;
    localparam logic [8:0] DIMPL = 9'h1FD;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [3:0]  core_evt;
    logic [8:0]  dma_evt;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [3:0] m_cs, m_ce;
    logic [8:0] m_ds, m_de;
    logic       m_mk;
    logic       exp_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    isr_unit i_isr_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .core_evt(core_evt), .dma_evt(dma_evt), .irq(irq)
    );

    function automatic logic irq_fn();
        return (|(m_cs & m_ce)) || ((|(m_ds & m_de)) && m_mk);
    endfunction

    function automatic logic [31:0] rd_fn(input logic [2:0] a);
        case (a)
            3'd0: return {28'd0, m_cs};
            3'd1: return {28'd0, m_ce};
            3'd2: return {23'd0, m_ds};
            3'd3: return {23'd0, m_de};
            3'd4: return {31'd0, m_mk};
            default: return 32'd0;
        endcase
    endfunction

    task automatic step(input logic [3:0] ec, input logic [8:0] ed,
                        input logic wr, input logic [2:0] a, input logic [31:0] d);
        core_evt = ec; dma_evt = ed; reg_wr = wr; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        exp_irq = irq_fn();
        if (wr) begin
            case (a)
                3'd0: m_cs = m_cs & ~d[3:0];
                3'd1: m_ce = d[3:0];
                3'd2: m_ds = m_ds & ~d[8:0];
                3'd3: m_de = d[8:0] & DIMPL;
                3'd4: m_mk = d[0];
                default: ;
            endcase
        end
        m_cs = m_cs | ec;
        m_ds = m_ds | (ed & DIMPL);
        @(negedge clk);
        core_evt = '0; dma_evt = '0; reg_wr = 1'b0;
    endtask

    task automatic chk_irq(input string tag);
        checks++;
        if (irq !== exp_irq) begin
            errors++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp_irq);
        end
    endtask

    task automatic chk_rd(input logic [2:0] a, input string tag);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== rd_fn(a)) begin
            errors++;
            $display("FAIL %s addr %0d actual=%h expected=%h", tag, a, reg_rdata, rd_fn(a));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned r;
        r = $urandom(32'd4242);
        rst_n = 1'b0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        core_evt = 0; dma_evt = 0;
        m_cs = 0; m_ce = 0; m_ds = 0; m_de = 0; m_mk = 0; exp_irq = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 8; a++) chk_rd(3'(a), "R1");
        chk_irq("R1");
        rst_n = 1'b1;
        @(negedge clk);

        // R2 latch with enables off, no irq
        step(4'b0100, 9'd0, 0, 0, 0); chk_irq("R2");
        step(4'b0000, 9'd0, 0, 0, 0); chk_irq("R2");
        chk_rd(0, "R2");
        // R3 DMA bits, bit 1 absent
        step(4'b0000, 9'h003, 0, 0, 0); chk_rd(2, "R3");
        step(4'b0000, 9'h100, 0, 0, 0); chk_rd(2, "R3");
        // R8 enable readback, bit1 of DMA dropped
        step(0, 0, 1, 3'd3, 32'hFFFF_FFFF); chk_rd(3, "R8");
        step(0, 0, 1, 3'd4, 32'h3); chk_rd(4, "R8");
        step(0, 0, 0, 0, 0); chk_irq("R6");
        // R7 mask closed blocks DMA
        step(0, 0, 1, 3'd4, 32'h0); step(0, 0, 0, 0, 0); chk_irq("R7");
        step(0, 0, 0, 0, 0); chk_irq("R7");
        // R4 partial clear
        step(0, 0, 1, 3'd2, 32'h001); chk_rd(2, "R4");
        step(0, 0, 1, 3'd2, 32'hFFFF_FFFF); chk_rd(2, "R4");
        // R5 collision
        step(4'b0001, 0, 1, 3'd0, 32'h1); chk_rd(0, "R5");
        step(4'b0000, 0, 1, 3'd0, 32'h1); chk_rd(0, "R4");
        // R9 unused address
        step(0, 0, 1, 3'd6, 32'hFFFF_FFFF); chk_rd(6, "R9");
        for (int a = 0; a < 5; a++) chk_rd(3'(a), "R9");
        // R10 error with done set, only error enabled
        step(0, 0, 1, 3'd1, 32'h8); step(4'b1100, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0); chk_irq("R10");
        step(0, 0, 1, 3'd0, 32'h8); step(0, 0, 0, 0, 0); chk_irq("R10");
        // R8 zero enable disables
        step(4'b1000, 0, 1, 3'd1, 32'h0); step(0, 0, 0, 0, 0); chk_irq("R8");

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [3:0]  ec;
            logic [8:0]  ed;
            logic        wr;
            logic [2:0]  a;
            logic [31:0] d;
            ec = ($urandom % 4 == 0) ? 4'($urandom) : 4'd0;
            ed = ($urandom % 4 == 0) ? 9'($urandom) : 9'd0;
            wr = ($urandom % 3 == 0);
            a  = 3'($urandom % 7);
            d  = ($urandom % 5 == 0) ? 32'hFFFF_FFFF : $urandom;
            step(ec, ed, wr, a, d);
            chk_irq("R6");
            chk_rd(3'($urandom % 8), "R4");
        end
        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule